// File: doc/BRIEF.md
# Width-Selectable Byte FIFO with Level Checks

This block is a first-in first-out buffer with a fixed capacity in bytes (256 by default). The entry size can be one, two or four bytes, and it can be changed at run time. The buffer fills from a valid/ready push port and drains through a valid/ready pop port, one entry per handshake. A push stores the low bytes of the 32-bit push word. A pop returns the entry zero-extended to 32 bits. The fill level is reported in entries of the current size.

Software controls the buffer through three write-strobed words:
- an operation word that flushes the buffer and starts or stops it;
- a control word that holds the entry-size code and a threshold counted in entries;
- a check-point word that holds three 6-bit marks, each counted in 4-byte units.

One parameter picks the direction. In the receive variant, the threshold fires at or above the programmed value, and a push into a full buffer sets a sticky overflow flag. In the transmit variant, the threshold fires at or below the programmed value.

Top module: `wfifo_top`

## Requirements
- R1: While the buffer is stopped (the state after reset, or after an operation write with bit 1 clear), push_ready and pop_valid are 0. A push offered while stopped leaves the level unchanged.
- R2: Entry-size code 0 gives 1-byte entries and a capacity of 256 entries. Only bits 7:0 of push_data are stored, and a pop returns them with bits 31:8 zero.
- R3: Entry-size code 1 gives 2-byte entries and a capacity of 128 entries. Only bits 15:0 of push_data are stored, and a pop returns them with bits 31:16 zero.
- R4: Entry-size code 2 gives 4-byte entries and a capacity of 64 entries. A pop returns the full 32-bit word.
- R5: Entries pop in the order they were pushed.
- R6: The status word holds the level modulo 256 in bits 7:0, full in bit 8 and empty in bit 9. When full, push_ready is 0.
- R7: The control word holds the threshold in bits 9:2 and the entry-size code in bits 1:0. For receive, thr_hit is 1 when level >= threshold. For transmit, thr_hit is 1 when level <= threshold.
- R8: The check-point word holds the low mark in bits 5:0, the mid mark in bits 11:6 and the high mark in bits 17:12. wm_hit[0], wm_hit[1] and wm_hit[2] are each 1 when the bytes held are at least 4 times the matching mark.
- R9: In the receive variant, a push offered while the buffer is running and full sets overflow. overflow stays set until a flush or reset. In the transmit variant, overflow stays 0.
- R10: An operation write with bit 0 set flushes the buffer. From the next cycle, the level is 0, empty is 1, pop_valid is 0 and overflow is 0.
- R11: A push and a pop accepted in the same cycle leave the level unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_wr | input | 1 | Operation word write strobe |
| op_val | input | 2 | Bit 0 flush, bit 1 run |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_val | input | 10 | Threshold [9:2], entry-size code [1:0] |
| chk_wr | input | 1 | Check-point word write strobe |
| chk_val | input | 18 | High [17:12], mid [11:6], low [5:0] marks |
| push_valid | input | 1 | Push request |
| push_data | input | 32 | Push data, low bytes used |
| push_ready | output | 1 | Push accepted this cycle |
| pop_valid | output | 1 | Entry available |
| pop_data | output | 32 | Head entry, zero-extended |
| pop_ready | input | 1 | Pop request |
| level | output | 9 | Fill level in entries |
| status | output | 10 | {empty, full, level[7:0]} |
| thr_hit | output | 1 | Threshold reached |
| wm_hit | output | 3 | Check-point marks reached {high, mid, low} |
| overflow | output | 1 | Sticky push-while-full flag |

## Verification
The bench fills the buffer to capacity at each entry size. A design that sized the buffer in entries instead of bytes would accept too many or too few entries at one of those sizes. At byte width it checks that a level of 256 shows as 0 in the 8-bit level field with full set, which a truncated level counter would get wrong. It drives a push and a pop in the same cycles, where a design that applied only one of the two would drift the level. It pushes into a full buffer and then flushes it, to catch an overflow flag that is not sticky or that survives the flush. The threshold is checked from both sides in the receive and transmit variants together, so a comparison with the wrong direction or an off-by-one boundary shows.

// File: rtl/wfifo_pkg.sv
package wfifo_pkg;
   typedef enum logic [1:0] {
      WID_BYTE = 2'd0,
      WID_HALF = 2'd1,
      WID_WORD = 2'd2
   } wid_e;

   typedef struct packed {
      logic [5:0] hi;
      logic [5:0] mid;
      logic [5:0] lo;
   } chk_t;

   // log2 of the entry size in bytes; an unused code behaves as word width
   function automatic logic [1:0] wid_shift(input logic [1:0] code);
      case (wid_e'(code))
         WID_BYTE: return 2'd0;
         WID_HALF: return 2'd1;
         default:  return 2'd2;
      endcase
   endfunction
endpackage

// File: rtl/wfifo_store.sv
module wfifo_store #(
   parameter int CAP_BYTES = 256,
   parameter int LANES     = 4,
   localparam int PTR_W    = $clog2(CAP_BYTES)
) (
   input  logic                 clk,
   input  logic [LANES-1:0]     we,
   input  logic [PTR_W-1:0]     waddr,
   input  logic [8*LANES-1:0]   wdata,
   input  logic [PTR_W-1:0]     raddr,
   output logic [8*LANES-1:0]   rdata
);
   logic [7:0] mem [CAP_BYTES];

   always_ff @(posedge clk) begin
      for (int i = 0; i < LANES; i++) begin
         if (we[i]) mem[PTR_W'(waddr + PTR_W'(i))] <= wdata[8*i +: 8];
      end
   end

   always_comb begin
      for (int i = 0; i < LANES; i++) begin
         rdata[8*i +: 8] = mem[PTR_W'(raddr + PTR_W'(i))];
      end
   end
endmodule

// File: rtl/wfifo_ctrl.sv
module wfifo_ctrl
   import wfifo_pkg::*;
#(
   parameter int CAP_BYTES = 256,
   parameter bit IS_RX     = 1'b1,
   localparam int PTR_W    = $clog2(CAP_BYTES),
   localparam int CNT_W    = PTR_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             op_wr,
   input  logic [1:0]       op_val,
   input  logic             ctl_wr,
   input  logic [9:0]       ctl_val,
   input  logic             chk_wr,
   input  chk_t             chk_in,
   input  logic             push_fire,
   input  logic             pop_fire,
   input  logic             push_block,
   output logic             running,
   output logic [1:0]       shift,
   output logic [7:0]       thr,
   output chk_t             chk,
   output logic [PTR_W-1:0] wptr,
   output logic [PTR_W-1:0] rptr,
   output logic [CNT_W-1:0] cnt,
   output logic             overflow
);
   logic [CNT_W-1:0] esz;
   logic             flush;

   assign esz   = CNT_W'(1) << shift;
   assign flush = op_wr && op_val[0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         running <= 1'b0;
         shift   <= 2'd0;
         thr     <= '0;
         chk     <= '0;
         wptr    <= '0;
         rptr    <= '0;
         cnt     <= '0;
      end else begin
         if (ctl_wr) begin
            thr   <= ctl_val[9:2];
            shift <= wid_shift(ctl_val[1:0]);
         end
         if (chk_wr) chk <= chk_in;
         if (op_wr) running <= op_val[1];
         if (flush) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
         end else begin
            if (push_fire) wptr <= wptr + esz[PTR_W-1:0];
            if (pop_fire)  rptr <= rptr + esz[PTR_W-1:0];
            case ({push_fire, pop_fire})
               2'b10:   cnt <= cnt + esz;
               2'b01:   cnt <= cnt - esz;
               default: cnt <= cnt;
            endcase
         end
      end
   end

   generate
      if (IS_RX) begin : g_ovf
         always_ff @(posedge clk) begin
            if (!rst_n || flush) overflow <= 1'b0;
            else if (push_block) overflow <= 1'b1;
         end
      end else begin : g_no_ovf
         assign overflow = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/wfifo_flags.sv
module wfifo_flags
   import wfifo_pkg::*;
#(
   parameter int CAP_BYTES = 256,
   parameter bit IS_RX     = 1'b1,
   localparam int CNT_W    = $clog2(CAP_BYTES) + 1
) (
   input  logic [CNT_W-1:0] cnt,
   input  logic [1:0]       shift,
   input  logic [7:0]       thr,
   input  chk_t             chk,
   output logic [CNT_W-1:0] level,
   output logic             full,
   output logic             empty,
   output logic             thr_hit,
   output logic [2:0]       wm_hit
);
   logic [CNT_W-1:0] esz;
   logic [5:0]       pts [3];

   assign esz   = CNT_W'(1) << shift;
   assign level = cnt >> shift;
   assign full  = (cnt + esz) > CNT_W'(CAP_BYTES);
   assign empty = cnt < esz;

   generate
      if (IS_RX) begin : g_rx_thr
         assign thr_hit = level >= CNT_W'(thr);
      end else begin : g_tx_thr
         assign thr_hit = level <= CNT_W'(thr);
      end
   endgenerate

   assign pts[0] = chk.lo;
   assign pts[1] = chk.mid;
   assign pts[2] = chk.hi;

   for (genvar g = 0; g < 3; g++) begin : g_wm
      assign wm_hit[g] = cnt >= (CNT_W'(pts[g]) << 2);
   end
endmodule

// File: rtl/wfifo_top.sv
module wfifo_top
   import wfifo_pkg::*;
#(
   parameter int CAP_BYTES = 256,
   parameter int DATA_W    = 32,
   parameter bit IS_RX     = 1'b1,
   localparam int PTR_W    = $clog2(CAP_BYTES),
   localparam int CNT_W    = PTR_W + 1,
   localparam int LANES    = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_wr,
   input  logic [1:0]        op_val,
   input  logic              ctl_wr,
   input  logic [9:0]        ctl_val,
   input  logic              chk_wr,
   input  logic [17:0]       chk_val,
   input  logic              push_valid,
   input  logic [DATA_W-1:0] push_data,
   output logic              push_ready,
   output logic              pop_valid,
   output logic [DATA_W-1:0] pop_data,
   input  logic              pop_ready,
   output logic [CNT_W-1:0]  level,
   output logic [9:0]        status,
   output logic              thr_hit,
   output logic [2:0]        wm_hit,
   output logic              overflow
);
   if (DATA_W != 32) begin : g_bad_width
      $fatal(1, "wfifo_top: DATA_W must be 32 to carry word entries");
   end
   if (CAP_BYTES < 8 || (CAP_BYTES & (CAP_BYTES - 1)) != 0) begin : g_bad_cap
      $fatal(1, "wfifo_top: CAP_BYTES must be a power of two, at least 8");
   end

   logic             running, full, empty;
   logic             push_fire, pop_fire, push_block;
   logic [1:0]       shift;
   logic [7:0]       thr;
   chk_t             chk;
   logic [PTR_W-1:0] wptr, rptr;
   logic [CNT_W-1:0] cnt;
   logic [LANES-1:0] lane_on;
   logic [DATA_W-1:0] rdata;

   assign push_ready = running && !full;
   assign pop_valid  = running && !empty;
   assign push_fire  = push_valid && push_ready;
   assign pop_fire   = pop_valid && pop_ready;
   assign push_block = push_valid && running && full;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      localparam int NEED = (g == 0) ? 0 : ((g == 1) ? 1 : 2);
      assign lane_on[g]         = int'(shift) >= NEED;
      assign pop_data[8*g +: 8] = lane_on[g] ? rdata[8*g +: 8] : 8'h00;
   end

   wfifo_ctrl #(.CAP_BYTES(CAP_BYTES), .IS_RX(IS_RX)) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .op_wr(op_wr), .op_val(op_val),
      .ctl_wr(ctl_wr), .ctl_val(ctl_val),
      .chk_wr(chk_wr), .chk_in(chk_t'(chk_val)),
      .push_fire(push_fire), .pop_fire(pop_fire), .push_block(push_block),
      .running(running), .shift(shift), .thr(thr), .chk(chk),
      .wptr(wptr), .rptr(rptr), .cnt(cnt), .overflow(overflow)
   );

   wfifo_store #(.CAP_BYTES(CAP_BYTES), .LANES(LANES)) u_store (
      .clk(clk),
      .we(lane_on & {LANES{push_fire}}),
      .waddr(wptr), .wdata(push_data),
      .raddr(rptr), .rdata(rdata)
   );

   wfifo_flags #(.CAP_BYTES(CAP_BYTES), .IS_RX(IS_RX)) u_flags (
      .cnt(cnt), .shift(shift), .thr(thr), .chk(chk),
      .level(level), .full(full), .empty(empty),
      .thr_hit(thr_hit), .wm_hit(wm_hit)
   );

   assign status = {empty, full, 8'(level)};
endmodule

// File: rtl/wfifo_chk.sv
module wfifo_chk #(
   parameter int LVL_W = 9,
   parameter bit IS_RX = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             op_wr,
   input logic [1:0]       op_val,
   input logic             ctl_wr,
   input logic             push_valid,
   input logic             push_ready,
   input logic             pop_valid,
   input logic             pop_ready,
   input logic [LVL_W-1:0] level,
   input logic             st_full,
   input logic             st_empty,
   input logic             overflow
);
   assert_stop_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (op_wr && !op_val[1]) |=> (!push_ready && !pop_valid));

   assert_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(st_full && st_empty));

   assert_ovf_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (IS_RX && push_valid && !push_ready && pop_valid && st_full
       && !(op_wr && op_val[0])) |=> overflow);

   assert_ovf_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (overflow && !(op_wr && op_val[0])) |=> overflow);

   assert_flush_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (op_wr && op_val[0]) |=> (level == '0 && st_empty && !overflow));

   assert_both_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (push_valid && push_ready && pop_valid && pop_ready && !op_wr && !ctl_wr)
      |=> $stable(level));
endmodule

bind wfifo_top wfifo_chk #(.LVL_W(CNT_W), .IS_RX(IS_RX)) u_chk (
   .clk(clk), .rst_n(rst_n), .op_wr(op_wr), .op_val(op_val), .ctl_wr(ctl_wr),
   .push_valid(push_valid), .push_ready(push_ready),
   .pop_valid(pop_valid), .pop_ready(pop_ready),
   .level(level), .st_full(status[8]), .st_empty(status[9]),
   .overflow(overflow)
);

// File: tb/sim_wfifo_top.sv
module sim_wfifo_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_wr = 0, ctl_wr = 0, chk_wr = 0;
   logic [1:0]  op_val = 0;
   logic [9:0]  ctl_val = 0;
   logic [17:0] chk_val = 0;
   logic        push_valid = 0, pop_ready = 0;
   logic [31:0] push_data = 0;

   logic        u0_pr, u0_pv, u0_thr, u0_ovf, u1_pr, u1_pv, u1_thr, u1_ovf;
   logic [31:0] u0_pd, u1_pd;
   logic [8:0]  u0_lvl, u1_lvl;
   logic [9:0]  u0_st, u1_st;
   logic [2:0]  u0_wm, u1_wm;

   int total = 0, fails = 0;
   bit done = 0;

   always #4 clk = ~clk;

   wfifo_top #(.IS_RX(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .op_wr(op_wr), .op_val(op_val),
      .ctl_wr(ctl_wr), .ctl_val(ctl_val), .chk_wr(chk_wr), .chk_val(chk_val),
      .push_valid(push_valid), .push_data(push_data), .push_ready(u0_pr),
      .pop_valid(u0_pv), .pop_data(u0_pd), .pop_ready(pop_ready),
      .level(u0_lvl), .status(u0_st), .thr_hit(u0_thr), .wm_hit(u0_wm),
      .overflow(u0_ovf));

   wfifo_top #(.IS_RX(1'b0)) u1 (
      .clk(clk), .rst_n(rst_n), .op_wr(op_wr), .op_val(op_val),
      .ctl_wr(ctl_wr), .ctl_val(ctl_val), .chk_wr(chk_wr), .chk_val(chk_val),
      .push_valid(push_valid), .push_data(push_data), .push_ready(u1_pr),
      .pop_valid(u1_pv), .pop_data(u1_pd), .pop_ready(pop_ready),
      .level(u1_lvl), .status(u1_st), .thr_hit(u1_thr), .wm_hit(u1_wm),
      .overflow(u1_ovf));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic do_op(input logic [1:0] v);
      @(negedge clk); op_wr = 1; op_val = v;
      @(negedge clk); op_wr = 0;
   endtask

   task automatic do_cfg(input logic [7:0] t, input logic [1:0] w);
      @(negedge clk); ctl_wr = 1; ctl_val = {t, w};
      @(negedge clk); ctl_wr = 0;
   endtask

   task automatic push1(input logic [31:0] d);
      @(negedge clk); push_valid = 1; push_data = d;
      @(negedge clk); push_valid = 0;
   endtask

   task automatic pop1(output logic [31:0] d);
      @(negedge clk); d = u0_pd; pop_ready = 1;
      @(negedge clk); pop_ready = 0;
   endtask

   task automatic t_reset;
      check("R6 reset status", 32'(u0_st), 32'h200);
      check("R1 reset push_ready", 32'(u0_pr), 0);
      check("R1 reset pop_valid", 32'(u0_pv), 0);
   endtask

   task automatic t_stopped;
      push1(32'h77);
      do_op(2'b10);
      check("R1 push while stopped ignored", 32'(u0_lvl), 0);
      check("R1 empty after ignored push", 32'(u0_pv), 0);
      do_op(2'b00);
      check("R1 stop clears push_ready", 32'(u0_pr), 0);
   endtask

   task automatic t_byte;
      logic [31:0] d;
      do_cfg(8'd4, 2'd0);
      do_op(2'b11);
      for (int i = 0; i < 256; i++) push1(32'h5A5A_5A00 | 32'(i));
      check("R2 byte capacity level", 32'(u0_lvl), 256);
      check("R6 full status word", 32'(u0_st), 32'h100);
      check("R6 push_ready low when full", 32'(u0_pr), 0);
      push1(32'hFF);
      check("R9 overflow set", 32'(u0_ovf), 1);
      check("R9 level unchanged by overflow", 32'(u0_lvl), 256);
      repeat (3) @(negedge clk);
      check("R9 overflow sticky", 32'(u0_ovf), 1);
      check("R9 transmit variant no overflow", 32'(u1_ovf), 0);
      for (int i = 0; i < 3; i++) begin
         pop1(d);
         check("R2 byte data truncated", d, 32'(i));
      end
      check("R6 level after pops", 32'(u0_st), 32'(253));
      do_op(2'b11);
      check("R10 flush level", 32'(u0_lvl), 0);
      check("R10 flush status", 32'(u0_st), 32'h200);
      check("R10 flush clears overflow", 32'(u0_ovf), 0);
      check("R10 flush pop_valid", 32'(u0_pv), 0);
   endtask

   task automatic t_half;
      logic [31:0] d;
      do_cfg(8'd0, 2'd1);
      do_op(2'b11);
      for (int i = 0; i < 128; i++) push1(32'hDEAD_0000 | 32'(i * 257));
      check("R3 half capacity level", 32'(u0_lvl), 128);
      check("R3 half full status", 32'(u0_st), 32'h180);
      for (int i = 0; i < 2; i++) begin
         pop1(d);
         check("R3 half data truncated", d, 32'(i * 257));
      end
   endtask

   task automatic t_word;
      logic [31:0] d;
      do_cfg(8'd0, 2'd2);
      do_op(2'b11);
      for (int i = 0; i < 64; i++) push1(32'h1000_0000 + 32'(i) * 32'h0301_0007);
      check("R4 word capacity level", 32'(u0_lvl), 64);
      check("R4 word full", 32'(u0_st[8]), 1);
      for (int i = 0; i < 64; i++) begin
         pop1(d);
         check("R5 word order", d, 32'h1000_0000 + 32'(i) * 32'h0301_0007);
      end
      check("R4 empty after drain", 32'(u0_st), 32'h200);
   endtask

   task automatic t_thresh;
      logic [31:0] d;
      do_cfg(8'd3, 2'd0);
      do_op(2'b11);
      check("R7 rx below threshold", 32'(u0_thr), 0);
      check("R7 tx at zero", 32'(u1_thr), 1);
      for (int i = 0; i < 3; i++) push1(32'(i));
      check("R7 rx at threshold", 32'(u0_thr), 1);
      check("R7 tx at threshold", 32'(u1_thr), 1);
      push1(32'h3);
      check("R7 rx above threshold", 32'(u0_thr), 1);
      check("R7 tx above threshold", 32'(u1_thr), 0);
      pop1(d);
      pop1(d);
      check("R7 rx back below", 32'(u0_thr), 0);
      check("R7 tx back below", 32'(u1_thr), 1);
   endtask

   task automatic t_wm;
      @(negedge clk); chk_wr = 1; chk_val = {6'd3, 6'd2, 6'd1};
      @(negedge clk); chk_wr = 0;
      do_cfg(8'd0, 2'd2);
      do_op(2'b11);
      check("R8 marks at empty", 32'(u0_wm), 0);
      push1(32'hA);
      check("R8 low mark", 32'(u0_wm), 3'b001);
      push1(32'hB);
      check("R8 mid mark", 32'(u0_wm), 3'b011);
      push1(32'hC);
      check("R8 high mark", 32'(u0_wm), 3'b111);
   endtask

   task automatic t_both;
      do_cfg(8'd0, 2'd0);
      do_op(2'b11);
      push1(32'd10);
      push1(32'd11);
      @(negedge clk);
      push_valid = 1; pop_ready = 1;
      for (int k = 0; k < 3; k++) begin
         push_data = 32'(20 + k);
         check("R11 head during push and pop", u0_pd, (k == 0) ? 32'd10 : ((k == 1) ? 32'd11 : 32'd20));
         @(negedge clk);
         check("R11 level held", 32'(u0_lvl), 2);
      end
      push_valid = 0; pop_ready = 0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_stopped();
      t_byte();
      t_half();
      t_word();
      t_thresh();
      t_wm();
      t_both();
      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end
endmodule